// File: doc/BRIEF.md
# Correctable Error Address Filter

This block screens the addresses of correctable memory faults so that software hears about each faulty location once. It compares every incoming fault address against a small content-addressable table. A fault whose 8-byte-aligned address is already held by an occupied entry is dropped silently. A new address is written into the lowest-numbered free entry, which then becomes occupied. The block can emit a one-cycle error event for it. Once the table is full, any further unique fault sets a sticky overflow flag and leaves the table as it was.

A register-style CPU port lets software read and write the control word, the status word, each entry's state code and each entry's stored address. Entry writes need a privileged access. In functional mode software can free an entry, or preload an address to mask a known hard fault without raising an event. A diagnostic key unlocks forcing entries into either state and makes address writes raise events, so the whole event path can be exercised.

Top module: `ce_addr_filter`

## Requirements
- R1: Fault addresses are matched on bits [31:3] only; bits [2:0] have no effect on the match, and an entry's stored address reads back with bits [2:0] zero.
- R2: A valid fault whose aligned address equals an occupied entry changes no entry, no flag and raises no event.
- R3: A unique valid fault is stored in the lowest-indexed free entry, that entry becomes occupied, and when ctrl bit 4 (event enable) is 1 evt_o pulses high in the cycle after the fault.
- R4: cpu_sel_i selects 0 control, 1 status, 2 entry state, 3 entry address, with cpu_idx_i picking the entry; cpu_rdata_o returns an entry state as 4'h5 when free and 4'hA when occupied, and the control word in bits [5:0].
- R5: Status bit 0 (full) becomes 1 in the same edge the last entry becomes occupied; writing 1 to it clears it only when an entry is free; irq_o equals full AND ctrl bit 5.
- R6: A unique fault while no entry is free sets status bit 1 (overflow), raises evt_o when enabled and leaves all entries unchanged; writing 1 to status bit 1 clears it.
- R7: avail_cnt_o and status bits [13:8] always equal the number of free entries after every hardware or CPU change.
- R8: Entry state and entry address writes with cpu_priv_i low are ignored.
- R9: With ctrl bits [3:0] not equal to 4'hA, a privileged state write of 4'h5 frees the entry, while 4'hA or any other code is ignored.
- R10: In functional mode a privileged address write stores bits [31:3] of cpu_wdata_i, marks the entry occupied and raises no event.
- R11: With ctrl bits [3:0] equal to 4'hA a state write of 4'hA also occupies the entry, and an address write raises evt_o when event enable is set.
- R12: A privileged entry write in the same cycle as a valid fault takes priority, and that fault is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flt_valid_i | input | 1 | Fault address valid this cycle |
| flt_addr_i | input | 32 | Byte address of the correctable fault |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_priv_i | input | 1 | CPU access is privileged |
| cpu_sel_i | input | 2 | Register select (0 ctrl, 1 status, 2 state, 3 address) |
| cpu_idx_i | input | 5 | Entry index for state and address accesses |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | CPU read data for the selected register |
| evt_o | output | 1 | One-cycle error event |
| irq_o | output | 1 | Table-full interrupt |
| full_o | output | 1 | Sticky full status |
| ovf_o | output | 1 | Sticky overflow status |
| avail_cnt_o | output | 6 | Number of free entries |

## Verification
The assertions assume that cpu_idx_i always names an existing entry and that the fault and CPU inputs are known, not X, whenever their strobes are high. They also assume that a fault is screened only in a cycle without a privileged entry write, and the properties are gated on exactly that condition. The random stimulus draws indices from the full legal range. It draws fault addresses from a small pool with random low bits, so repeats, allocations and overflows all occur. Control writes sometimes carry the diagnostic key, so both modes interleave with fault traffic.

// File: rtl/cef_pkg.sv
package cef_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_STATE = 2'd2,
    SEL_DATA = 2'd3
  } cef_sel_e;

  localparam logic [3:0] CODE_FREE = 4'h5;
  localparam logic [3:0] CODE_USED = 4'hA;
  localparam logic [3:0] KEY_DIAG  = 4'hA;

  typedef struct packed {
    logic       irq_en;
    logic       evt_en;
    logic [3:0] key;
  } cef_ctrl_t;
endpackage

// File: rtl/cef_match.sv
module cef_match #(
  parameter int N_ENT = 32,
  parameter int TAG_W = 29
) (
  input  logic [N_ENT-1:0][TAG_W-1:0] tags_i,
  input  logic [N_ENT-1:0]            occ_i,
  input  logic [TAG_W-1:0]            key_i,
  output logic                        hit_o
);
  logic [N_ENT-1:0] eq;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign eq[g] = occ_i[g] && (tags_i[g] == key_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/cef_alloc.sv
module cef_alloc #(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] occ_i,
  output logic [IDX_W-1:0] grant_o,
  output logic             any_free_o,
  output logic [CNT_W-1:0] avail_cnt_o
);
  // lowest free index wins
  always_comb begin
    grant_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!occ_i[i]) grant_o = IDX_W'(i);
    end
  end

  always_comb begin
    avail_cnt_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      avail_cnt_o = avail_cnt_o + CNT_W'(!occ_i[i]);
    end
  end

  assign any_free_o = ~&occ_i;

  assert_cnt_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free_o == (avail_cnt_o != '0));

  assert_grant_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free_o |-> !occ_i[grant_o]);
endmodule

// File: rtl/ce_addr_filter.sv
module ce_addr_filter #(
  parameter int N_ENT     = 32,
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 3,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1),
  localparam int TAG_W = ADDR_W - ALIGN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flt_valid_i,
  input  logic [ADDR_W-1:0] flt_addr_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_priv_i,
  input  logic [1:0]        cpu_sel_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [31:0]       cpu_wdata_i,
  output logic [31:0]       cpu_rdata_o,
  output logic              evt_o,
  output logic              irq_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  avail_cnt_o
);
  import cef_pkg::*;

  logic [N_ENT-1:0][TAG_W-1:0] tags_q;
  logic [N_ENT-1:0]            occ_q, occ_d;
  cef_ctrl_t                   ctrl_q;
  logic                        full_q, ovf_q, evt_q;

  cef_sel_e         sel;
  logic             diag, ent_acc, data_wr, state_wr;
  logic             hit, any_free, alloc, ovf_set, flt_go;
  logic             clr_full, clr_ovf;
  logic [IDX_W-1:0] grant;
  logic [TAG_W-1:0] flt_tag, cpu_tag;
  logic             unused_lsb;

  assign sel        = cef_sel_e'(cpu_sel_i);
  assign diag       = (ctrl_q.key == KEY_DIAG);
  assign ent_acc    = cpu_wr_i && cpu_priv_i && (sel == SEL_STATE || sel == SEL_DATA);
  assign data_wr    = ent_acc && (sel == SEL_DATA);
  assign state_wr   = ent_acc && (sel == SEL_STATE);
  assign flt_tag    = flt_addr_i[ADDR_W-1:ALIGN_LSB];
  assign cpu_tag    = cpu_wdata_i[ADDR_W-1:ALIGN_LSB];
  assign unused_lsb = ^flt_addr_i[ALIGN_LSB-1:0];

  cef_match #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_match (
    .tags_i (tags_q),
    .occ_i  (occ_q),
    .key_i  (flt_tag),
    .hit_o  (hit)
  );

  cef_alloc #(.N_ENT(N_ENT)) u_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .occ_i       (occ_q),
    .grant_o     (grant),
    .any_free_o  (any_free),
    .avail_cnt_o (avail_cnt_o)
  );

  // CPU entry writes win over fault screening
  assign flt_go  = flt_valid_i && !ent_acc;
  assign alloc   = flt_go && !hit && any_free;
  assign ovf_set = flt_go && !hit && !any_free;

  assign clr_full = cpu_wr_i && (sel == SEL_STAT) && cpu_wdata_i[0];
  assign clr_ovf  = cpu_wr_i && (sel == SEL_STAT) && cpu_wdata_i[1];

  always_comb begin
    occ_d = occ_q;
    if (data_wr) begin
      occ_d[cpu_idx_i] = 1'b1;
    end else if (state_wr) begin
      if (cpu_wdata_i[3:0] == CODE_FREE)              occ_d[cpu_idx_i] = 1'b0;
      else if (cpu_wdata_i[3:0] == CODE_USED && diag) occ_d[cpu_idx_i] = 1'b1;
    end else if (alloc) begin
      occ_d[grant] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q <= '0;
    end else if (data_wr) begin
      tags_q[cpu_idx_i] <= cpu_tag;
    end else if (alloc) begin
      tags_q[grant] <= flt_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      ctrl_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      if (cpu_wr_i && sel == SEL_CTRL) ctrl_q <= cef_ctrl_t'(cpu_wdata_i[5:0]);
      full_q <= (&occ_d) || (full_q && !clr_full);
      ovf_q  <= ovf_set || (ovf_q && !clr_ovf);
      evt_q  <= ctrl_q.evt_en && (alloc || ovf_set || (data_wr && diag));
    end
  end

  always_comb begin
    cpu_rdata_o = '0;
    case (sel)
      SEL_CTRL:  cpu_rdata_o[5:0] = ctrl_q;
      SEL_STAT: begin
        cpu_rdata_o[0]           = full_q;
        cpu_rdata_o[1]           = ovf_q;
        cpu_rdata_o[8 +: CNT_W]  = avail_cnt_o;
      end
      SEL_STATE: cpu_rdata_o[3:0] = occ_q[cpu_idx_i] ? CODE_USED : CODE_FREE;
      SEL_DATA:  cpu_rdata_o[ADDR_W-1:0] = {tags_q[cpu_idx_i], {ALIGN_LSB{1'b0}}};
      default:   cpu_rdata_o = '0;
    endcase
  end

  assign evt_o  = evt_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign irq_o  = full_q && ctrl_q.irq_en;

  assert_repeat_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && hit && !ent_acc) |=> ($stable(occ_q) && !evt_o));

  assert_alloc_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && !hit && any_free && !ent_acc) |=>
      ($countones(occ_q) == $past($countones(occ_q)) + 1));

  assert_alloc_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && !hit && any_free && !ent_acc && ctrl_q.evt_en) |=> evt_o);

  assert_full_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&occ_q) |-> full_o);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_valid_i && !hit && !any_free && !ent_acc) |=> (ovf_o && $stable(occ_q)));

  assert_unpriv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_priv_i && !flt_valid_i) |=> $stable(occ_q));

  assert_func_noset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_wr && !diag) |=> ($countones(occ_q) <= $past($countones(occ_q))));

  assert_func_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !diag) |=> !evt_o);
endmodule

// File: tb/ce_addr_filter_tb.sv
`timescale 1ns/1ps
module ce_addr_filter_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [31:0] fa = '0;
  logic        wr = 1'b0;
  logic        priv = 1'b0;
  logic [1:0]  sel = '0;
  logic [4:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        evt, irq, full, ovf;
  logic [5:0]  avail;

  always #4 clk = ~clk;

  ce_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flt_valid_i(fv), .flt_addr_i(fa),
    .cpu_wr_i(wr), .cpu_priv_i(priv), .cpu_sel_i(sel), .cpu_idx_i(idx),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .evt_o(evt), .irq_o(irq),
    .full_o(full), .ovf_o(ovf), .avail_cnt_o(avail)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  bit          m_occ [N];
  logic [28:0] m_tag [N];
  logic [5:0]  m_ctrl = '0;
  bit          m_full = 1'b0, m_ovf = 1'b0, e_evt = 1'b0;

  function automatic int m_avail();
    int c = 0;
    for (int i = 0; i < N; i++) if (!m_occ[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] s, int i);
    case (s)
      2'd0: return {26'b0, m_ctrl};
      2'd1: return (32'(m_avail()) << 8) | (32'(m_ovf) << 1) | 32'(m_full);
      2'd2: return m_occ[i] ? 32'hA : 32'h5;
      default: return {m_tag[i], 3'b000};
    endcase
  endfunction

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // reference update from the requirements, using the driven inputs
  task automatic model_step();
    logic [5:0] oc = m_ctrl;
    bit diag = (oc[3:0] == 4'hA);
    bit ent = wr && priv && sel[1];
    bit clr_f = 1'b0, clr_o = 1'b0, ovf_set = 1'b0, all_occ = 1'b1;
    e_evt = 1'b0;
    if (wr && sel == 2'd0) m_ctrl = wdata[5:0];
    if (wr && sel == 2'd1) begin clr_f = wdata[0]; clr_o = wdata[1]; end
    if (ent) begin
      if (sel == 2'd3) begin
        m_tag[idx] = wdata[31:3];
        m_occ[idx] = 1'b1;
        e_evt = diag && oc[4];
      end else if (wdata[3:0] == 4'h5) m_occ[idx] = 1'b0;
      else if (wdata[3:0] == 4'hA && diag) m_occ[idx] = 1'b1;
    end else if (fv) begin
      bit hit = 1'b0;
      int fr = -1;
      for (int i = 0; i < N; i++) begin
        if (m_occ[i] && m_tag[i] == fa[31:3]) hit = 1'b1;
        if (!m_occ[i] && fr < 0) fr = i;
      end
      if (!hit) begin
        e_evt = oc[4];
        if (fr >= 0) begin m_occ[fr] = 1'b1; m_tag[fr] = fa[31:3]; end
        else ovf_set = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) if (!m_occ[i]) all_occ = 1'b0;
    m_full = all_occ || (m_full && !clr_f);
    m_ovf  = ovf_set || (m_ovf && !clr_o);
  endtask

  task automatic step(string r);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(r, "evt", 32'(evt), 32'(e_evt));
    chk(r, "avail", 32'(avail), 32'(m_avail()));
    chk(r, "full", 32'(full), 32'(m_full));
    chk(r, "ovf", 32'(ovf), 32'(m_ovf));
    chk(r, "irq", 32'(irq), 32'(m_full && m_ctrl[5]));
    fv = 1'b0; wr = 1'b0; priv = 1'b0;
  endtask

  task automatic fault(logic [31:0] a, string r);
    fv = 1'b1; fa = a;
    step(r);
  endtask

  task automatic cwr(logic [1:0] s, int i, logic [31:0] d, bit p, string r);
    wr = 1'b1; sel = s; idx = 5'(i); wdata = d; priv = p;
    step(r);
  endtask

  task automatic rd(logic [1:0] s, int i, string r);
    sel = s; idx = 5'(i);
    #1;
    chk(r, "rdata", rdata, exp_rd(s, i));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd20240611);
    for (int i = 0; i < N; i++) begin m_occ[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R7", "reset avail", 32'(avail), 32'(N));
    chk("R5", "reset full", 32'(full), 0);
    chk("R6", "reset ovf", 32'(ovf), 0);
    chk("R3", "reset evt", 32'(evt), 0);
    rst_n = 1'b1;
    rd(2'd2, 0, "R4");
    rd(2'd0, 0, "R4");

    cwr(2'd0, 0, 32'h30, 1'b1, "R4");
    rd(2'd0, 0, "R4");
    fault(32'h0000_1000, "R3");
    rd(2'd2, 0, "R4");
    rd(2'd3, 0, "R1");
    fault(32'h0000_1007, "R1");
    fault(32'h0000_1000, "R2");
    fault(32'h0000_1008, "R3");
    rd(2'd3, 1, "R1");

    cwr(2'd3, 5, 32'h0000_5000, 1'b0, "R8");
    cwr(2'd2, 0, 32'h5, 1'b0, "R8");
    rd(2'd2, 5, "R8");
    rd(2'd2, 0, "R8");
    cwr(2'd2, 6, 32'hA, 1'b1, "R9");
    rd(2'd2, 6, "R9");
    cwr(2'd2, 1, 32'h7, 1'b1, "R9");
    rd(2'd2, 1, "R9");
    cwr(2'd2, 0, 32'h5, 1'b1, "R9");
    rd(2'd2, 0, "R9");
    fault(32'h0000_2000, "R3");
    rd(2'd3, 0, "R3");

    cwr(2'd3, 7, 32'h0800_0000, 1'b1, "R10");
    rd(2'd2, 7, "R10");
    rd(2'd3, 7, "R10");
    fault(32'h0800_0004, "R10");

    fv = 1'b1; fa = 32'h0000_3000;
    cwr(2'd3, 8, 32'h0000_9000, 1'b1, "R12");
    fault(32'h0000_3000, "R12");

    while (m_avail() > 0) fault(32'h0001_0000 + 32'(m_avail()) * 8, "R7");
    rd(2'd1, 0, "R5");
    fault(32'h0002_0000, "R6");
    rd(2'd1, 0, "R6");
    cwr(2'd1, 0, 32'h1, 1'b1, "R5");
    cwr(2'd1, 0, 32'h2, 1'b1, "R6");
    fault(32'h0000_1000, "R2");

    cwr(2'd0, 0, 32'h3A, 1'b1, "R11");
    cwr(2'd2, 3, 32'h5, 1'b1, "R11");
    cwr(2'd1, 0, 32'h1, 1'b1, "R5");
    cwr(2'd2, 3, 32'hA, 1'b1, "R11");
    rd(2'd2, 3, "R11");
    cwr(2'd3, 3, 32'h0000_7770, 1'b1, "R11");
    cwr(2'd2, 4, 32'h5, 1'b1, "R11");
    cwr(2'd3, 4, 32'h0000_7778, 1'b0, "R8");
    cwr(2'd0, 0, 32'h10, 1'b1, "R9");

    for (int it = 0; it < 3000; it++) begin
      int op = $urandom % 10;
      fv = ($urandom % 3) != 0;
      fa = 32'h0000_4000 + ($urandom % 48) * 8 + ($urandom % 8);
      if (op == 6) begin
        int c = $urandom % 3;
        wr = 1'b1; sel = 2'd2; idx = 5'($urandom % N); priv = ($urandom % 4) != 0;
        wdata = (c == 0) ? 32'h5 : (c == 1) ? 32'hA : $urandom;
      end else if (op == 7) begin
        wr = 1'b1; sel = 2'd3; idx = 5'($urandom % N); priv = ($urandom % 4) != 0;
        wdata = 32'h0000_4000 + ($urandom % 48) * 8;
      end else if (op == 8) begin
        wr = 1'b1; sel = 2'd1; wdata = $urandom % 4;
      end else if (op == 9 && ($urandom % 4) == 0) begin
        wr = 1'b1; sel = 2'd0;
        wdata = {26'b0, 2'($urandom), (($urandom % 3) == 0) ? 4'hA : 4'($urandom)};
      end
      step("R2 R3 R5 R6 R7 R9 R11 R12");
      if ((it % 16) == 0) begin
        int e = $urandom % N;
        rd(2'd2, e, "R4");
        rd(2'd3, e, "R1");
        rd(2'd1, 0, "R7");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule